// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block keeps the programmed burst settings of a synchronous DRAM controller and, for every read or write burst, steps through the column addresses that the burst touches. A controller writes a 7-bit key to choose the burst length, the beat ordering and the CAS latency. A start strobe with an 8-bit column opens a burst. From the next clock on, the block gives one column per cycle until the burst runs out or is cut short.

Two orderings are offered. Sequential ordering counts upward and wraps inside the block of columns aligned to the burst length. Interleaved ordering XORs the beat number into the low column bits. A whole-page setting walks all 256 columns in sequential order, wrapping at the top, until the controller stops it. A start strobe during a burst drops the burst in flight and begins a new one, so commands can follow each other on every clock. The decoded CAS latency is exported for the controller's data pipeline. A key that uses a reserved code is refused and flagged.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `burst_busy`, `last_beat` and `key_err` are 0, `cas_lat` is 2, and the stored setting is a one-beat sequential burst.
- R2: Key bits [2:0] choose the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `burst_busy` is high for exactly that many cycles, starting the cycle after `burst_go`. `last_beat` is high on the final beat only, and `burst_busy` falls on the following cycle.
- R3: Key bit 3 = 0 selects sequential order. The low log2(length) column bits equal the start value plus the beat number, modulo the length. The higher bits keep the start value.
- R4: Key bit 3 = 1 selects interleaved order. The low log2(length) column bits equal the start value XOR the beat number. The higher bits keep the start value.
- R5: Key bits [6:4] give the CAS latency (001 = 1, 010 = 2, 011 = 3). It appears on `cas_lat` the cycle after an accepted key write and does not change without a key write.
- R6: Length code 111 with sequential order is a whole-page burst. The column equals start plus beat modulo 256, `last_beat` never rises, and the burst continues until it is stopped or restarted.
- R7: A key with length code 100, 101 or 110, with length 111 together with interleave, or with CAS code 000 or 100 to 111 sets `key_err` on the next cycle and leaves the stored setting unchanged. An accepted key clears `key_err`.
- R8: `burst_go` during a burst starts a new burst from the new column on the next cycle. It can be given on consecutive cycles. When `burst_go` and `burst_stop` come in the same cycle, `burst_go` wins.
- R9: `burst_stop` without `burst_go` drops `burst_busy` on the next cycle.
- R10: A burst keeps the length and order in force at its `burst_go`. A key write during the burst affects only later bursts.
- R11: While no burst is running, `col_out` holds the last column it gave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Key write strobe |
| mode_key | input | 7 | Key: [6:4] latency, [3] order, [2:0] length |
| key_err | output | 1 | Last key write was refused |
| cas_lat | output | 2 | Decoded CAS latency |
| burst_go | input | 1 | Start a burst |
| start_col | input | 8 | First column of the burst |
| burst_stop | input | 1 | End the burst in flight |
| col_out | output | 8 | Current column |
| burst_busy | output | 1 | A burst beat is on `col_out` |
| last_beat | output | 1 | This is the final beat |

## Verification
The hardest cases are those where control strobes arrive while a burst is still running. Examples are a restart on the very next cycle, back-to-back restarts, a restart and a stop together, and a key write in the middle of an eight-beat burst. The bench reaches them by driving these strobes on chosen negative edges inside a burst. A whole-page burst is run for more than 256 beats to cross the column wrap. The test then stops it and checks that the column stays put.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
    localparam int COL_W   = 8;
    localparam int KEY_W   = 7;
    localparam int CL_W    = 2;
    localparam int LEN_LSB = 0;
    localparam int ORD_BIT = 3;
    localparam int CL_LSB  = 4;

    typedef struct packed {
        logic [COL_W-1:0] mask;  // length - 1, all ones for whole page
        logic             full;
        logic             ilv;
        logic [CL_W-1:0]  cas;
    } mode_t;

    localparam mode_t MODE_RST = '{mask: '0, full: 1'b0, ilv: 1'b0, cas: CL_W'(2)};
endpackage

// File: rtl/col_mode_reg.sv
module col_mode_reg
    import col_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [KEY_W-1:0] mode_key,
    output mode_t            mode,
    output logic             key_err
);
    typedef struct packed {
        mode_t mode;
        logic  err;
    } mreg_t;

    mreg_t cur_q, nxt_d;
    mode_t cand;
    logic  len_ok, cl_ok;
    logic [2:0] len_code, cl_code;

    assign len_code = mode_key[LEN_LSB +: 3];
    assign cl_code  = mode_key[CL_LSB +: 3];

    always_comb begin
        cand      = cur_q.mode;
        cand.ilv  = mode_key[ORD_BIT];
        cand.full = 1'b0;
        cand.cas  = cl_code[CL_W-1:0];
        len_ok    = 1'b1;
        case (len_code)
            3'b000: cand.mask = COL_W'(0);
            3'b001: cand.mask = COL_W'(1);
            3'b010: cand.mask = COL_W'(3);
            3'b011: cand.mask = COL_W'(7);
            3'b111: begin
                cand.mask = '1;
                cand.full = 1'b1;
                len_ok    = ~mode_key[ORD_BIT];
            end
            default: begin
                cand.mask = cur_q.mode.mask;
                len_ok    = 1'b0;
            end
        endcase
        cl_ok = (cl_code == 3'd1) || (cl_code == 3'd2) || (cl_code == 3'd3);

        nxt_d = cur_q;
        if (mode_wr) begin
            if (len_ok && cl_ok) begin
                nxt_d.mode = cand;
                nxt_d.err  = 1'b0;
            end else begin
                nxt_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{mode: MODE_RST, err: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign mode    = cur_q.mode;
    assign key_err = cur_q.err;

    // R7
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !(len_ok && cl_ok)) |=> (key_err && mode == $past(mode)));
    // R5
    idle_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> ($stable(mode) && $stable(key_err)));
    // R5
    cas_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.cas != '0);
endmodule

// File: rtl/col_burst_ctr.sv
module col_burst_ctr
    import col_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             burst_go,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             last
);
    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] base;
        mode_t            cfg;
    } ctr_t;

    ctr_t cur_q, nxt_d;
    logic [COL_W-1:0] seq_low, ilv_low, low;

    assign last    = cur_q.busy && !cur_q.cfg.full && (cur_q.beat == cur_q.cfg.mask);
    assign seq_low = cur_q.base + cur_q.beat;
    assign ilv_low = cur_q.base ^ cur_q.beat;
    assign low     = cur_q.cfg.ilv ? ilv_low : seq_low;

    for (genvar i = 0; i < COL_W; i++) begin : g_colbit
        assign col[i] = cur_q.cfg.mask[i] ? low[i] : cur_q.base[i];
    end

    always_comb begin
        nxt_d = cur_q;
        if (burst_go) begin
            nxt_d.busy = 1'b1;
            nxt_d.beat = '0;
            nxt_d.base = start_col;
            nxt_d.cfg  = mode;
        end else if (burst_stop) begin
            nxt_d.busy = 1'b0;
        end else if (cur_q.busy) begin
            if (last) nxt_d.busy = 1'b0;
            else      nxt_d.beat = cur_q.beat + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{busy: 1'b0, beat: '0, base: '0, cfg: MODE_RST};
        else        cur_q <= nxt_d;
    end

    assign busy = cur_q.busy;

    // R8
    go_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (busy && col == $past(start_col)));
    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_go) |=> !busy);
    // R2
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !burst_go) |=> !busy);
    // R6
    full_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_q.cfg.full && !burst_go && !burst_stop) |=> busy);
    // R10
    cfg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_go |=> $stable(cur_q.cfg));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !burst_go) |=> $stable(col));
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import col_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [KEY_W-1:0] mode_key,
    output logic             key_err,
    output logic [CL_W-1:0]  cas_lat,
    input  logic             burst_go,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             burst_busy,
    output logic             last_beat
);
    mode_t cur_mode;

    col_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_key (mode_key),
        .mode     (cur_mode),
        .key_err  (key_err)
    );

    col_burst_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cur_mode),
        .burst_go   (burst_go),
        .start_col  (start_col),
        .burst_stop (burst_stop),
        .col        (col_out),
        .busy       (burst_busy),
        .last       (last_beat)
    );

    assign cas_lat = cur_mode.cas;

    // R2
    last_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> burst_busy);
endmodule

// File: tb/sdram_col_seq_test.sv
`timescale 1ns/1ps
module sdram_col_seq_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_wr;
    logic [6:0] mode_key;
    logic       key_err;
    logic [1:0] cas_lat;
    logic       burst_go;
    logic [7:0] start_col;
    logic       burst_stop;
    logic [7:0] col_out;
    logic       burst_busy;
    logic       last_beat;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdram_col_seq uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_key(mode_key),
        .key_err(key_err), .cas_lat(cas_lat), .burst_go(burst_go),
        .start_col(start_col), .burst_stop(burst_stop), .col_out(col_out),
        .burst_busy(burst_busy), .last_beat(last_beat)
    );

    // key, start column
    localparam logic [14:0] VEC [6] = '{
        {7'b0100010, 8'h0E},   // CL2, 4 beats, sequential
        {7'b0111011, 8'h35},   // CL3, 8 beats, interleave
        {7'b0010001, 8'hFF},   // CL1, 2 beats, sequential
        {7'b0100000, 8'h42},   // CL2, 1 beat
        {7'b0110011, 8'h7D},   // CL3, 8 beats, sequential
        {7'b0011010, 8'hA6}    // CL1, 4 beats, interleave
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_col(input logic [7:0] st, input int bl,
                                           input bit ilv, input int beat);
        logic [7:0] m, b, lo;
        m  = 8'(bl - 1);
        b  = 8'(beat);
        lo = ilv ? (st ^ b) : (st + b);
        return (st & ~m) | (lo & m);
    endfunction

    task automatic set_mode(input logic [6:0] k);
        mode_wr  = 1'b1;
        mode_key = k;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic run_burst(input logic [7:0] st, input int bl, input bit ilv);
        burst_go  = 1'b1;
        start_col = st;
        @(negedge clk);
        burst_go  = 1'b0;
        for (int b = 0; b < bl; b++) begin
            chk(burst_busy === 1'b1, "R2 busy", burst_busy, 1);
            chk(col_out === exp_col(st, bl, ilv, b), ilv ? "R4 col" : "R3 col",
                col_out, exp_col(st, bl, ilv, b));
            chk(last_beat === (b == bl - 1), "R2 last", last_beat, (b == bl - 1));
            @(negedge clk);
        end
        chk(burst_busy === 1'b0, "R2 end", burst_busy, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_wr = 1'b0; mode_key = '0;
        burst_go = 1'b0; start_col = '0; burst_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(burst_busy === 1'b0, "R1 busy", burst_busy, 0);
        chk(last_beat === 1'b0, "R1 last", last_beat, 0);
        chk(key_err === 1'b0, "R1 key_err", key_err, 0);
        chk(cas_lat === 2'd2, "R1 cas", cas_lat, 2);
        run_burst(8'h42, 1, 1'b0);   // R1 default one-beat sequential

        // table walk: R2 R3 R4 R5
        foreach (VEC[i]) begin
            logic [6:0] k;
            k = VEC[i][14:8];
            set_mode(k);
            chk(key_err === 1'b0, "R5 key ok", key_err, 0);
            chk(cas_lat === k[5:4], "R5 cas", cas_lat, k[5:4]);
            run_burst(VEC[i][7:0], 1 << k[2:0], k[3]);
        end

        // R6 whole page, past the wrap, then stop (R9) and hold (R11)
        set_mode(7'b0100111);
        chk(key_err === 1'b0, "R6 key ok", key_err, 0);
        burst_go = 1'b1; start_col = 8'hFE;
        @(negedge clk);
        burst_go = 1'b0;
        for (int b = 0; b < 300; b++) begin
            chk(burst_busy === 1'b1 && last_beat === 1'b0, "R6 running",
                {burst_busy, last_beat}, 2'b10);
            chk(col_out === 8'(8'hFE + b), "R6 col", col_out, 8'(8'hFE + b));
            @(negedge clk);
        end
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk(burst_busy === 1'b0, "R9 stop", burst_busy, 0);
        chk(col_out === 8'h2A, "R11 hold", col_out, 8'h2A);
        @(negedge clk);
        chk(col_out === 8'h2A, "R11 hold2", col_out, 8'h2A);

        // R8 restarts
        set_mode(7'b0100010);
        burst_go = 1'b1; start_col = 8'h10;
        @(negedge clk);
        burst_go = 1'b0;
        chk(col_out === 8'h10, "R8 first", col_out, 8'h10);
        @(negedge clk);
        chk(col_out === 8'h11, "R8 second", col_out, 8'h11);
        burst_go = 1'b1; start_col = 8'h21;
        @(negedge clk);
        chk(burst_busy === 1'b1 && col_out === 8'h21, "R8 restart", col_out, 8'h21);
        start_col = 8'h33;
        @(negedge clk);
        chk(col_out === 8'h33, "R8 back-to-back", col_out, 8'h33);
        start_col = 8'h44; burst_stop = 1'b1;
        @(negedge clk);
        burst_go = 1'b0; burst_stop = 1'b0;
        chk(burst_busy === 1'b1 && col_out === 8'h44, "R8 go wins", col_out, 8'h44);
        @(negedge clk);
        chk(col_out === 8'h45, "R8 continue", col_out, 8'h45);
        @(negedge clk);
        @(negedge clk);
        chk(col_out === 8'h47 && last_beat === 1'b1, "R8 last", col_out, 8'h47);
        @(negedge clk);
        chk(burst_busy === 1'b0, "R8 end", burst_busy, 0);

        // R9 stop mid-burst
        set_mode(7'b0110011);
        burst_go = 1'b1; start_col = 8'h50;
        @(negedge clk);
        burst_go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(col_out === 8'h52, "R9 before stop", col_out, 8'h52);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk(burst_busy === 1'b0, "R9 dropped", burst_busy, 0);
        chk(col_out === 8'h52, "R11 after stop", col_out, 8'h52);

        // R10 key write inside an 8-beat burst
        burst_go = 1'b1; start_col = 8'h60;
        @(negedge clk);
        burst_go = 1'b0;
        mode_wr = 1'b1; mode_key = 7'b0100001;
        for (int b = 0; b < 8; b++) begin
            chk(burst_busy === 1'b1 && col_out === exp_col(8'h60, 8, 1'b0, b),
                "R10 col", col_out, exp_col(8'h60, 8, 1'b0, b));
            chk(last_beat === (b == 7), "R10 last", last_beat, (b == 7));
            @(negedge clk);
            mode_wr = 1'b0;
        end
        chk(burst_busy === 1'b0, "R10 end", burst_busy, 0);
        chk(cas_lat === 2'd2, "R10 new cas", cas_lat, 2);
        run_burst(8'h61, 2, 1'b0);

        // R7 refused keys
        set_mode(7'b0100101);
        chk(key_err === 1'b1 && cas_lat === 2'd2, "R7 len 101", {key_err, cas_lat}, 3'b110);
        set_mode(7'b0000010);
        chk(key_err === 1'b1 && cas_lat === 2'd2, "R7 cl 000", {key_err, cas_lat}, 3'b110);
        set_mode(7'b0111111);
        chk(key_err === 1'b1 && cas_lat === 2'd2, "R7 ilv page", {key_err, cas_lat}, 3'b110);
        set_mode(7'b1000010);
        chk(key_err === 1'b1 && cas_lat === 2'd2, "R7 cl 100", {key_err, cas_lat}, 3'b110);
        run_burst(8'h61, 2, 1'b0);   // R7 setting unchanged
        set_mode(7'b0011010);
        chk(key_err === 1'b0 && cas_lat === 2'd1, "R7 cleared", {key_err, cas_lat}, 3'b001);
        run_burst(8'hA6, 4, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule